// File: doc/BRIEF.md
# Run-Time Programmable Four-Stage LFSR Pseudo-Random Source

This block produces a pseudo-random sequence of 4-bit values from a four-stage linear feedback shift register. The feedback taps are not wired in; they come from a coefficient register that is written at run time. One circuit therefore covers every connection polynomial of length four. A seed sets the starting value. The register then moves forward one step each time a slow strobe fires. The strobe comes from a terminal-count divider on the system clock. The present value leaves the block as a seven-segment glyph.

The control logic is a two-state machine. `ST_IDLE` is entered on reset, and there the register never steps. The transition *start* (init_run high in `ST_IDLE`) loads the seed and moves to `ST_RUN`. In `ST_RUN` the register steps on strobe pulses. The transition *reseed* (init_run high in `ST_RUN`) reloads the seed and stays in `ST_RUN`. Only reset leaves `ST_RUN`. A coefficient load never changes the machine state.

Top module: `lfsr4_prng`

## Requirements
- R1: While rst_n is low, and on the first cycles after it rises with no command applied, the register holds 0. seg_out then shows the glyph for 0 (7'h3F) and strobe_out is low.
- R2: When load_coeff is high at a clock edge, coeff is captured into the coefficient register and the LFSR value does not change at that edge, even if a strobe falls on it. Later steps use the new coefficients.
- R3: When init_run is high at a clock edge, the value becomes seed. seed bit 3 is s3, the newest bit, and seed bit 0 is s0, the oldest. The machine enters or stays in ST_RUN.
- R4: Each step turns [s3,s2,s1,s0] into [n,s3,s2,s1], where n = (coeff[0]&s3) ^ (coeff[1]&s2) ^ (coeff[2]&s1) ^ (coeff[3]&s0). coeff[0] is c1 and coeff[3] is c4.
- R5: strobe_out is a one-cycle pulse that repeats every DIV_COUNT clock cycles.
- R6: In ST_RUN the value changes only at an edge where strobe_out is high. Between strobe pulses it holds.
- R7: seg_out is active high, with bit 6 = g down to bit 0 = a. For the value 0..F it shows 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 in that order.
- R8: A seed of 0 stays at 0 for every coefficient word.
- R9: With coeff = 4'b1001 (1 + D + D^4) and a non-zero seed, the value returns to the seed after exactly 15 steps.
- R10: The init_run edge clears the divider. The first strobe pulse is DIV_COUNT-1 cycles after that edge, and the first step lands DIV_COUNT edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed | input | 4 | Start value, bit 3 = s3 |
| coeff | input | 4 | Tap word, bit 0 = c1 ... bit 3 = c4 |
| load_coeff | input | 1 | Capture coeff at this edge |
| init_run | input | 1 | Load seed and run |
| strobe_out | output | 1 | Divided step strobe |
| seg_out | output | 7 | Segment pattern g..a of the present value |

## Verification
The seed appears on seg_out in the cycle after the edge that samples init_run. strobe_out rises DIV_COUNT-1 cycles after that edge. Each step shows up exactly DIV_COUNT edges after the one before it. seg_out is a decode of the register with no delay of its own, so it follows the register in the same cycle. The driver tags each expected glyph or strobe level with the cycle in which it is due. The monitor compares on the falling edge of exactly that cycle, including the cycle just before each step, where the old value must still hold.

// File: rtl/lfsr4_pkg.sv
package lfsr4_pkg;
    localparam int LFSR_LEN = 4;
    localparam int SEG_W    = 7;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/lfsr4_strobe_div.sv
module lfsr4_strobe_div #(
    parameter int DIV_COUNT = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic strobe
);
    generate
        if (DIV_COUNT <= 1) begin : g_passthru
            assign strobe = 1'b1;
        end else begin : g_count
            localparam int CNT_W = $clog2(DIV_COUNT);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_COUNT - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (restart || cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign strobe = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/lfsr4_core.sv
module lfsr4_core
    import lfsr4_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LFSR_LEN-1:0] seed,
    input  logic [LFSR_LEN-1:0] coeff,
    input  logic                load_coeff,
    input  logic                init_run,
    input  logic                strobe,
    output logic [LFSR_LEN-1:0] state,
    output logic                running
);
    run_state_t             fsm_q, fsm_d;
    logic [LFSR_LEN-1:0]    taps_q;
    logic [LFSR_LEN-1:0]    lfsr_q;
    logic [LFSR_LEN-1:0]    terms;
    logic                   fb;
    logic                   do_step;

    // tap k (c_{k+1}) multiplies the bit k+1 steps back: s3 for c1 ... s0 for c4
    genvar k;
    generate
        for (k = 0; k < LFSR_LEN; k++) begin : g_tap
            assign terms[k] = taps_q[k] & lfsr_q[LFSR_LEN-1-k];
        end
    endgenerate
    assign fb = ^terms;

    // next-state logic of the run controller
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_IDLE: if (init_run) fsm_d = ST_RUN;   // start
            ST_RUN:  fsm_d = ST_RUN;                 // reseed or keep running
            default: fsm_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= ST_IDLE;
        else        fsm_q <= fsm_d;
    end

    assign do_step = (fsm_q == ST_RUN) && strobe && !load_coeff && !init_run;

    // datapath registers driven by the controller
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps_q <= '0;
            lfsr_q <= '0;
        end else begin
            if (load_coeff) taps_q <= coeff;
            if (init_run) begin
                lfsr_q <= seed;
            end else if (do_step) begin
                lfsr_q <= {fb, lfsr_q[LFSR_LEN-1:1]};
            end
        end
    end

    assign state   = lfsr_q;
    assign running = (fsm_q == ST_RUN);
endmodule

// File: rtl/lfsr4_seg_decode.sv
module lfsr4_seg_decode
    import lfsr4_pkg::*;
(
    input  logic [LFSR_LEN-1:0] value,
    output logic [SEG_W-1:0]    seg
);
    // bit 6 = g ... bit 0 = a, active high
    always_comb begin
        unique case (value)
            4'h0: seg = 7'h3F;
            4'h1: seg = 7'h06;
            4'h2: seg = 7'h5B;
            4'h3: seg = 7'h4F;
            4'h4: seg = 7'h66;
            4'h5: seg = 7'h6D;
            4'h6: seg = 7'h7D;
            4'h7: seg = 7'h07;
            4'h8: seg = 7'h7F;
            4'h9: seg = 7'h6F;
            4'hA: seg = 7'h77;
            4'hB: seg = 7'h7C;
            4'hC: seg = 7'h39;
            4'hD: seg = 7'h5E;
            4'hE: seg = 7'h79;
            4'hF: seg = 7'h71;
            default: seg = 7'h00;
        endcase
    end
endmodule

// File: rtl/lfsr4_prng.sv
module lfsr4_prng
    import lfsr4_pkg::*;
#(
    parameter int DIV_COUNT = 50_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LFSR_LEN-1:0] seed,
    input  logic [LFSR_LEN-1:0] coeff,
    input  logic                load_coeff,
    input  logic                init_run,
    output logic                strobe_out,
    output logic [SEG_W-1:0]    seg_out
);
    logic                strobe;
    logic                running;
    logic [LFSR_LEN-1:0] lfsr_state;

    lfsr4_strobe_div #(.DIV_COUNT(DIV_COUNT)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (init_run),
        .strobe  (strobe)
    );

    lfsr4_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed       (seed),
        .coeff      (coeff),
        .load_coeff (load_coeff),
        .init_run   (init_run),
        .strobe     (strobe),
        .state      (lfsr_state),
        .running    (running)
    );

    lfsr4_seg_decode u_seg (
        .value (lfsr_state),
        .seg   (seg_out)
    );

    assign strobe_out = strobe;
endmodule

// File: rtl/lfsr4_checker.sv
module lfsr4_checker #(
    parameter int DIV_COUNT = 50_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       init_run,
    input logic       load_coeff,
    input logic [3:0] seed,
    input logic       strobe,
    input logic       running,
    input logic [3:0] lfsr_state
);
    // R3: seed captured on init_run
    p_seed_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_run |=> (lfsr_state == $past(seed) && running));

    // R6: no change without a strobe
    p_hold_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !init_run) |=> $stable(lfsr_state));

    // R2: coefficient load freezes the value
    p_coeff_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_coeff && !init_run) |=> $stable(lfsr_state));

    // R4: a step shifts the older bits down by one place
    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && running && !load_coeff && !init_run)
        |=> (lfsr_state[2:0] == $past(lfsr_state[3:1])));

    // R8: zero is a fixed point
    p_zero_stuck_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_state == 4'h0 && !init_run) |=> (lfsr_state == 4'h0));

    generate
        if (DIV_COUNT > 1) begin : g_pulse
            // R5: strobe lasts a single cycle
            p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
                strobe |=> !strobe);
            // R10: divider restarts on init_run
            p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
                init_run |=> !strobe);
        end
    endgenerate
endmodule

bind lfsr4_prng lfsr4_checker #(.DIV_COUNT(DIV_COUNT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_run   (init_run),
    .load_coeff (load_coeff),
    .seed       (seed),
    .strobe     (strobe),
    .running    (running),
    .lfsr_state (lfsr_state)
);

// File: tb/tb_lfsr4_prng.sv
module tb_lfsr4_prng;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] seed = '0;
    logic [3:0] coeff = '0;
    logic       load_coeff = 1'b0;
    logic       init_run = 1'b0;
    logic       strobe_out;
    logic [6:0] seg_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lfsr4_prng #(.DIV_COUNT(DIV)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed       (seed),
        .coeff      (coeff),
        .load_coeff (load_coeff),
        .init_run   (init_run),
        .strobe_out (strobe_out),
        .seg_out    (seg_out)
    );

    typedef struct {
        int         due;
        bit         is_strobe;
        logic [6:0] val;
        string      tag;
    } item_t;

    item_t q[$];

    function automatic logic [6:0] glyph(input logic [3:0] v);
        case (v)
            4'h0: return 7'h3F;  4'h1: return 7'h06;  4'h2: return 7'h5B;  4'h3: return 7'h4F;
            4'h4: return 7'h66;  4'h5: return 7'h6D;  4'h6: return 7'h7D;  4'h7: return 7'h07;
            4'h8: return 7'h7F;  4'h9: return 7'h6F;  4'hA: return 7'h77;  4'hB: return 7'h7C;
            4'hC: return 7'h39;  4'hD: return 7'h5E;  4'hE: return 7'h79;  default: return 7'h71;
        endcase
    endfunction

    function automatic logic [3:0] step(input logic [3:0] s, input logic [3:0] c);
        logic n;
        n = (c[0] & s[3]) ^ (c[1] & s[2]) ^ (c[2] & s[1]) ^ (c[3] & s[0]);
        return {n, s[3:1]};
    endfunction

    function automatic void push(input int d, input bit st, input logic [6:0] v, input string t);
        item_t it;
        it.due = d; it.is_strobe = st; it.val = v; it.tag = t;
        q.push_back(it);
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // monitor: compare every item due in the present cycle
    always @(negedge clk) begin
        item_t it;
        while (q.size() > 0 && q[0].due <= cyc) begin
            it = q.pop_front();
            if (it.is_strobe) check(it.tag, {6'b0, strobe_out}, it.val);
            else              check(it.tag, seg_out, it.val);
        end
    end

    // driver: load taps, seed, then schedule each expected value
    task automatic run_seq(input logic [3:0] s, input logic [3:0] c, input int n,
                           input string tag, input int swap_at, input logic [3:0] swap_c);
        logic [3:0] m;
        logic [3:0] mc;
        int k;
        @(negedge clk); coeff = c; load_coeff = 1'b1;
        @(negedge clk); load_coeff = 1'b0; seed = s; init_run = 1'b1;
        k = cyc + 1; m = s; mc = c;
        push(k, 1'b0, glyph(m), tag);
        if (n > 0) begin
            if (DIV > 1) push(k + DIV - 2, 1'b1, 7'd0, "R5 R10");
            push(k + DIV - 1, 1'b1, 7'd1, "R5 R10");
            if (DIV > 1) push(k + DIV - 1, 1'b0, glyph(m), "R6");
        end
        @(negedge clk); init_run = 1'b0;
        for (int i = 1; i <= n; i++) begin
            while (cyc != k + i * DIV - 1) @(negedge clk);
            if (i == swap_at) begin
                coeff = swap_c; load_coeff = 1'b1; mc = swap_c;
            end else begin
                m = step(m, mc);
            end
            push(k + i * DIV, 1'b0, glyph(m), (i == swap_at) ? "R2" : tag);
            if (i < n && DIV > 1) push(k + (i + 1) * DIV - 1, 1'b0, glyph(m), "R6");
            @(negedge clk); load_coeff = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", seg_out, 7'h3F);
        check("R1", {6'b0, strobe_out}, 7'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", seg_out, 7'h3F);
        check("R1", {6'b0, strobe_out}, 7'd0);

        run_seq(4'h1, 4'b1001, 15, "R9", -1, 4'h0);     // full period returns to seed
        run_seq(4'h0, 4'b1001, 5,  "R8", -1, 4'h0);     // all-zero stays stuck
        run_seq(4'hA, 4'b0011, 8,  "R4", -1, 4'h0);
        run_seq(4'h6, 4'b1111, 6,  "R4", -1, 4'h0);
        run_seq(4'h8, 4'b1001, 5,  "R4", 2, 4'b0110);   // R2: tap swap on a strobe edge
        for (int v = 0; v < 16; v++) run_seq(4'(v), 4'b0000, 0, "R7", -1, 4'h0);
        run_seq(4'hF, 4'b1001, 3,  "R3", -1, 4'h0);     // reseed while running

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        summary();
        $finish;
    end
endmodule